// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt Core

This block is the host-facing register front end of a SCSI bus controller. The host sees sixteen byte-wide registers. Each address has a separate write-side copy and read-side copy, so a value written to an address is not always the value read back from it. One address is the port of a byte FIFO. Writing the command address starts a one-byte command. The block keeps the transfer counter, the status, interrupt and sequence-step registers, an ATN flag and a connected flag, and it drives one level interrupt output.

Simple commands are executed here: FIFO flush, chip reset, bus reset, ATN set and clear, message accepted, and no-op. Selection and transfer commands go to an external bus sequencer. The block sends it a registered request pulse and later takes back a completion report with phase, step, interrupt causes and terminal count. The host clears a pending interrupt by reading the interrupt register.

Top module: `scsi_regcore`

## Requirements
- R1: The register index is `addr_i[5:2]` when `stride4_i` is 1 and `addr_i[3:0]` when it is 0. An address with any bit set above the index field (bit 6 and up in stride mode, bit 4 and up in byte mode) is ignored on write and reads as 0x00.
- R2: Split views: index 0, 1 and 14 read the bytes of the loaded 24-bit counter (low, middle, high), not the written values. Index 3 and 9 to 12 read back the last written byte. Index 13 and 15 read 0x00.
- R3: Index 2 is a 16-byte FIFO. A write pushes, a read pops in arrival order, a push when full is dropped, and a pop when empty returns 0x00 and changes nothing. Command 0x01 empties the FIFO.
- R4: Index 7 reads {step[2:0], FIFO count[4:0]}.
- R5: After reset, counter high (index 14) reads 0x94, clock-conversion (index 9) reads 0x02, and all other read-side registers read 0x00 (index 8 per R6).
- R6: Bits 2:0 of index 8 always read 7, the controller's own ID. Bits 7:3 read the written value.
- R7: A command byte with bit 7 set loads the counter from the written bytes of index 0, 1 and 14, and it clears status bit 4 (terminal count).
- R8: A read of index 5 while status bit 7 (interrupt) is set returns the interrupt byte. It then clears the interrupt and step registers and sets status to 0x02, which drops the interrupt. A read of index 5 while status bit 7 is clear changes nothing.
- R9: Command 0x03 (bus reset) sets interrupt bits 7 and 3. It sets status bit 7 only if bit 6 of the written index 8 is 0, and it clears the connected flag. Every command write clears interrupt bit 7 before its own effect.
- R10: Command 0x1A sets `atn_o` and 0x1B clears it. Command 0x12 (message accepted) sets interrupt bit 5, status bit 7 and step 4, and it clears the connected flag.
- R11: An undefined command code sets interrupt bit 6 and status bit 7. The same happens for a sequencer command while an earlier one is still busy, and no request is issued.
- R12: Codes 0x10, 0x11, 0x18, 0x41 to 0x44 and 0x46 (bit 7 aside) raise `seq_req_o` for one cycle, on the cycle after the write, with the full byte on `seq_cmd_o`. A completion pulse taken while busy does the following: status phase bits 2:0 take `seq_phase_i` (0 data-out, 1 data-in, 2 command, 3 status, 6 message-out, 7 message-in), step takes `seq_step_i`, `seq_intr_i` is ORed into the interrupt byte, and status bit 7 is set. If `seq_tc_i` is set, status bit 4 is set and the counter becomes 0. The connected flag becomes the inverse of `seq_intr_i[5]`. A completion while not busy is ignored.
- R13: Command 0x02 restores the R5 state: FIFO empty, ATN clear, disconnected, not busy.
- R14: `int_o` equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stride4_i | input | 1 | 1: index from address bits 5:2, 0: bits 3:0 |
| addr_i | input | ADDR_W | Host byte address |
| wr_en_i | input | 1 | Host write strobe (wins over read) |
| rd_en_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for the current read, 0 otherwise |
| int_o | output | 1 | Level interrupt |
| atn_o | output | 1 | ATN flag |
| connected_o | output | 1 | Connected to a target |
| seq_req_o | output | 1 | One-cycle request to the sequencer |
| seq_cmd_o | output | 8 | Command byte for the sequencer |
| seq_id_o | output | 3 | Target ID from written index 4 |
| seq_done_i | input | 1 | Sequencer completion pulse |
| seq_phase_i | input | 3 | Bus phase reported at completion |
| seq_step_i | input | 3 | Sequence step reported at completion |
| seq_intr_i | input | 8 | Interrupt causes reported at completion |
| seq_tc_i | input | 1 | Terminal count reached |

## Verification
The hardest case to reach is a second sequencer command that arrives while the first is still outstanding. The bench therefore holds back its completion pulse and issues a transfer command during the busy window. It then checks for an illegal-command interrupt, checks that no second request appears, and checks that the late completion still updates phase, step and counter. The report-disable case of the bus reset is also hard to see. It leaves interrupt bits set with no pending interrupt, so the bench reads the interrupt register twice to show that the read-clear does not fire.

// File: rtl/scsi_regcore_pkg.sv
package scsi_regcore_pkg;
   localparam int REG_COUNT = 16;
   localparam int IDX_W     = 4;

   localparam logic [IDX_W-1:0] IX_CNT0 = 4'd0;
   localparam logic [IDX_W-1:0] IX_CNT1 = 4'd1;
   localparam logic [IDX_W-1:0] IX_FIFO = 4'd2;
   localparam logic [IDX_W-1:0] IX_CMD  = 4'd3;
   localparam logic [IDX_W-1:0] IX_STAT = 4'd4;
   localparam logic [IDX_W-1:0] IX_INTR = 4'd5;
   localparam logic [IDX_W-1:0] IX_STEP = 4'd6;
   localparam logic [IDX_W-1:0] IX_FLAG = 4'd7;
   localparam logic [IDX_W-1:0] IX_CFG1 = 4'd8;
   localparam logic [IDX_W-1:0] IX_CNT2 = 4'd14;

   localparam int IB_BUSRST = 7;
   localparam int IB_ILLEGAL = 6;
   localparam int IB_DISC   = 5;
   localparam int IB_FDONE  = 3;
   localparam int CFG1_NOREPORT = 6;

   localparam logic [2:0] PH_COMMAND = 3'd2;

   typedef enum logic [3:0] {
      CK_NOP, CK_FLUSH, CK_CHIPRST, CK_BUSRST, CK_MSGACC,
      CK_ATNSET, CK_ATNCLR, CK_SEQ, CK_BAD
   } cmd_kind_e;

   function automatic logic [7:0] wside_reset(int i);
      case (i)
         14:      return 8'h94;
         9:       return 8'h02;
         6:       return 8'h05;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/scsi_addr_map.sv
module scsi_addr_map #(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              stride4_i,
   output logic [3:0]        idx_o,
   output logic              hit_o
);
   logic hit_wide, hit_byte;

   if (ADDR_W < 6) begin : g_chk
      $error("scsi_addr_map: ADDR_W must be at least 6");
   end

   if (ADDR_W > 6) begin : g_wide_hi
      assign hit_wide = (addr_i[ADDR_W-1:6] == '0);
   end else begin : g_wide_none
      assign hit_wide = 1'b1;
   end
   assign hit_byte = (addr_i[ADDR_W-1:4] == '0);

   assign idx_o = stride4_i ? addr_i[5:2] : addr_i[3:0];
   assign hit_o = stride4_i ? hit_wide : hit_byte;
endmodule

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
   import scsi_regcore_pkg::*;
(
   input  logic [7:0] cmd_i,
   output cmd_kind_e  kind_o,
   output logic       dma_o
);
   assign dma_o = cmd_i[7];

   always_comb begin
      case (cmd_i[6:0])
         7'h00: kind_o = CK_NOP;
         7'h01: kind_o = CK_FLUSH;
         7'h02: kind_o = CK_CHIPRST;
         7'h03: kind_o = CK_BUSRST;
         7'h12: kind_o = CK_MSGACC;
         7'h1A: kind_o = CK_ATNSET;
         7'h1B: kind_o = CK_ATNCLR;
         7'h10, 7'h11, 7'h18,
         7'h41, 7'h42, 7'h43, 7'h44, 7'h46: kind_o = CK_SEQ;
         default: kind_o = CK_BAD;
      endcase
   end
endmodule

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             flush_i,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] head_o,
   output logic [CNT_W-1:0] count_o
);
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_chk
      $error("scsi_byte_fifo: DEPTH must be a power of two >= 2");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             full, empty, do_push, do_pop;

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push_i && !full && !flush_i;
   assign do_pop  = pop_i && !empty && !flush_i;

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wp_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush_i) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign head_o  = empty ? '0 : mem_q[rp_q];
   assign count_o = cnt_q;

   // R3
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   // R3
   pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty && !push_i && !flush_i) |=> (count_o == '0));
   // R3
   push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full && !pop_i && !flush_i) |=> $stable(count_o));
endmodule

// File: rtl/scsi_regcore.sv
module scsi_regcore
   import scsi_regcore_pkg::*;
#(
   parameter int         ADDR_W     = 8,
   parameter int         FIFO_DEPTH = 16,
   parameter logic [2:0] OWN_ID     = 3'd7,
   localparam int        FCNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stride4_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   output logic              int_o,
   output logic              atn_o,
   output logic              connected_o,
   output logic              seq_req_o,
   output logic [7:0]        seq_cmd_o,
   output logic [2:0]        seq_id_o,
   input  logic              seq_done_i,
   input  logic [2:0]        seq_phase_i,
   input  logic [2:0]        seq_step_i,
   input  logic [7:0]        seq_intr_i,
   input  logic              seq_tc_i
);
   if (FIFO_DEPTH > 31) begin : g_chk
      $error("scsi_regcore: FIFO count must fit the 5-bit flag field");
   end

   logic [IDX_W-1:0] idx;
   logic             hit, wr_hit, rd_hit, cmd_fire, chip_rst, bad_cmd, seq_fire;
   logic             seq_take, intr_clear, dma_cmd;
   cmd_kind_e        kind;
   logic [7:0]       fifo_head;
   logic [FCNT_W-1:0] fifo_cnt;

   logic [7:0]  wo_q [REG_COUNT];
   logic [23:0] cnt_q, cnt_n;
   logic        int_q, int_n, tc_q, tc_n;
   logic [2:0]  phase_q, phase_n, step_q, step_n;
   logic [7:0]  intr_q, intr_n;
   logic        atn_q, atn_n, conn_q, conn_n, busy_q, busy_n;
   logic        req_q, req_n;
   logic [7:0]  rcmd_q, rcmd_n;

   scsi_addr_map #(.ADDR_W(ADDR_W)) u_map (
      .addr_i(addr_i), .stride4_i(stride4_i), .idx_o(idx), .hit_o(hit));

   scsi_cmd_decode u_dec (.cmd_i(wdata_i), .kind_o(kind), .dma_o(dma_cmd));

   assign wr_hit     = wr_en_i && hit;
   assign rd_hit     = rd_en_i && !wr_en_i && hit;
   assign cmd_fire   = wr_hit && (idx == IX_CMD);
   assign chip_rst   = cmd_fire && (kind == CK_CHIPRST);
   assign seq_fire   = cmd_fire && (kind == CK_SEQ) && !busy_q;
   assign bad_cmd    = cmd_fire && ((kind == CK_BAD) || ((kind == CK_SEQ) && busy_q));
   assign seq_take   = seq_done_i && busy_q;
   assign intr_clear = rd_hit && (idx == IX_INTR) && int_q;

   scsi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_i(wr_hit && (idx == IX_FIFO)),
      .pop_i(rd_hit && (idx == IX_FIFO)),
      .flush_i(cmd_fire && ((kind == CK_FLUSH) || (kind == CK_CHIPRST))),
      .din_i(wdata_i), .head_o(fifo_head), .count_o(fifo_cnt));

   // write-side register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_COUNT; i++) wo_q[i] <= wside_reset(i);
      end else if (chip_rst) begin
         for (int i = 0; i < REG_COUNT; i++) wo_q[i] <= wside_reset(i);
      end else if (wr_hit && (idx != IX_FIFO)) begin
         wo_q[idx] <= wdata_i;
      end
   end

   // control and read-side state
   always_comb begin
      cnt_n   = cnt_q;
      int_n   = int_q;
      tc_n    = tc_q;
      phase_n = phase_q;
      step_n  = step_q;
      intr_n  = intr_q;
      atn_n   = atn_q;
      conn_n  = conn_q;
      busy_n  = busy_q;
      req_n   = 1'b0;
      rcmd_n  = rcmd_q;
      if (cmd_fire) begin
         intr_n[IB_BUSRST] = 1'b0;
         if (dma_cmd) begin
            cnt_n = {wo_q[IX_CNT2], wo_q[IX_CNT1], wo_q[IX_CNT0]};
            tc_n  = 1'b0;
         end
         case (kind)
            CK_BUSRST: begin
               intr_n[IB_BUSRST] = 1'b1;
               intr_n[IB_FDONE]  = 1'b1;
               if (!wo_q[IX_CFG1][CFG1_NOREPORT]) int_n = 1'b1;
               conn_n = 1'b0;
            end
            CK_MSGACC: begin
               intr_n[IB_DISC] = 1'b1;
               int_n  = 1'b1;
               step_n = 3'd4;
               conn_n = 1'b0;
            end
            CK_ATNSET: atn_n = 1'b1;
            CK_ATNCLR: atn_n = 1'b0;
            CK_SEQ: begin
               if (!busy_q) begin
                  busy_n = 1'b1;
                  req_n  = 1'b1;
                  rcmd_n = wdata_i;
               end
            end
            default: ;
         endcase
         if (bad_cmd) begin
            intr_n[IB_ILLEGAL] = 1'b1;
            int_n = 1'b1;
         end
      end
      if (intr_clear) begin
         intr_n  = '0;
         step_n  = '0;
         int_n   = 1'b0;
         tc_n    = 1'b0;
         phase_n = PH_COMMAND;
      end
      if (seq_take) begin
         busy_n  = 1'b0;
         phase_n = seq_phase_i;
         step_n  = seq_step_i;
         intr_n  = intr_n | seq_intr_i;
         int_n   = 1'b1;
         conn_n  = !seq_intr_i[IB_DISC];
         if (seq_tc_i) begin
            tc_n  = 1'b1;
            cnt_n = '0;
         end
      end
      if (chip_rst) begin
         cnt_n   = {wside_reset(14), 16'h0000};
         int_n   = 1'b0;
         tc_n    = 1'b0;
         phase_n = '0;
         step_n  = '0;
         intr_n  = '0;
         atn_n   = 1'b0;
         conn_n  = 1'b0;
         busy_n  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= {wside_reset(14), 16'h0000};
         int_q   <= 1'b0;
         tc_q    <= 1'b0;
         phase_q <= '0;
         step_q  <= '0;
         intr_q  <= '0;
         atn_q   <= 1'b0;
         conn_q  <= 1'b0;
         busy_q  <= 1'b0;
         req_q   <= 1'b0;
         rcmd_q  <= '0;
      end else begin
         cnt_q   <= cnt_n;
         int_q   <= int_n;
         tc_q    <= tc_n;
         phase_q <= phase_n;
         step_q  <= step_n;
         intr_q  <= intr_n;
         atn_q   <= atn_n;
         conn_q  <= conn_n;
         busy_q  <= busy_n;
         req_q   <= req_n;
         rcmd_q  <= rcmd_n;
      end
   end

   // read-side mux
   always_comb begin
      rdata_o = '0;
      if (rd_hit) begin
         case (idx)
            IX_CNT0: rdata_o = cnt_q[7:0];
            IX_CNT1: rdata_o = cnt_q[15:8];
            IX_CNT2: rdata_o = cnt_q[23:16];
            IX_FIFO: rdata_o = fifo_head;
            IX_STAT: rdata_o = {int_q, 2'b00, tc_q, 1'b0, phase_q};
            IX_INTR: rdata_o = intr_q;
            IX_STEP: rdata_o = {5'b00000, step_q};
            IX_FLAG: rdata_o = {step_q, 5'(fifo_cnt)};
            IX_CFG1: rdata_o = {wo_q[IX_CFG1][7:3], OWN_ID};
            4'd3, 4'd9, 4'd10, 4'd11, 4'd12: rdata_o = wo_q[idx];
            default: rdata_o = '0;
         endcase
      end
   end

   assign int_o       = int_q;
   assign atn_o       = atn_q;
   assign connected_o = conn_q;
   assign seq_req_o   = req_q;
   assign seq_cmd_o   = rcmd_q;
   assign seq_id_o    = wo_q[IX_STAT][2:0];

   // R8
   intr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !wr_en_i && hit && idx == IX_INTR && int_o && !seq_take)
      |=> (!int_o && phase_q == PH_COMMAND && intr_q == '0));
   // R7
   dma_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && wdata_i[7] && !seq_take) |=> !tc_q);
   // R11
   illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cmd |=> (int_o && intr_q[IB_ILLEGAL]));
   // R12
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_req_o |=> !seq_req_o);
   // R9
   busrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && kind == CK_BUSRST && !seq_take) |=> (!connected_o && intr_q[IB_BUSRST]));
endmodule

// File: tb/scsi_regcore_tb_top.sv
module scsi_regcore_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stride4 = 1'b1;
   logic [7:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       int_o, atn_o, conn_o, req_o;
   logic [7:0] cmd_o;
   logic [2:0] id_o;
   logic       sdone = 1'b0;
   logic [2:0] sphase = '0, sstep = '0;
   logic [7:0] sintr = '0;
   logic       stc = 1'b0;

   int checks = 0, errors = 0;
   bit finished = 0;
   bit model_on = 0;

   always #5 clk = ~clk;

   scsi_regcore dut_i (
      .clk(clk), .rst_n(rst_n), .stride4_i(stride4), .addr_i(addr),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
      .int_o(int_o), .atn_o(atn_o), .connected_o(conn_o),
      .seq_req_o(req_o), .seq_cmd_o(cmd_o), .seq_id_o(id_o),
      .seq_done_i(sdone), .seq_phase_i(sphase), .seq_step_i(sstep),
      .seq_intr_i(sintr), .seq_tc_i(stc));

   // ---------------- behavioural reference model ----------------
   int  m_wo [16];
   int  m_cnt, m_phase, m_step, m_intr;
   bit  m_int, m_tc, m_atn, m_conn, m_busy, m_req;
   int  m_rcmd;
   byte unsigned m_q [$];

   function automatic int m_wreset(int i);
      return (i == 14) ? 'h94 : (i == 9) ? 2 : (i == 6) ? 5 : 0;
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 16; i++) m_wo[i] = m_wreset(i);
      m_cnt = 'h940000; m_phase = 0; m_step = 0; m_intr = 0;
      m_int = 0; m_tc = 0; m_atn = 0; m_conn = 0; m_busy = 0; m_req = 0;
      m_rcmd = 0;
      m_q.delete();
   endtask

   function automatic bit m_hit();
      return stride4 ? (addr < 8'h40) : (addr < 8'h10);
   endfunction

   function automatic int m_idx();
      return stride4 ? int'(addr[5:2]) : int'(addr[3:0]);
   endfunction

   function automatic int m_rdata();
      int i;
      if (!(rd_en && !wr_en && m_hit())) return 0;
      i = m_idx();
      case (i)
         0: return m_cnt & 'hFF;
         1: return (m_cnt >> 8) & 'hFF;
         14: return (m_cnt >> 16) & 'hFF;
         2: return (m_q.size() > 0) ? int'(m_q[0]) : 0;
         4: return (m_int ? 'h80 : 0) | (m_tc ? 'h10 : 0) | m_phase;
         5: return m_intr;
         6: return m_step;
         7: return (m_step << 5) | m_q.size();
         8: return (m_wo[8] & 'hF8) | 7;
         3, 9, 10, 11, 12: return m_wo[i];
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else begin
         int  i, c;
         bit  wh, rh, take;
         wh = wr_en && m_hit();
         rh = rd_en && !wr_en && m_hit();
         i  = m_idx();
         take = sdone && m_busy;
         m_req = 0;
         if (wh && i == 2) begin
            if (m_q.size() < 16) m_q.push_back(wdata);
         end else if (wh && i != 2) m_wo[i] = wdata;
         if (rh && i == 2 && m_q.size() > 0) void'(m_q.pop_front());
         if (wh && i == 3) begin
            c = wdata & 'h7F;
            m_intr = m_intr & 'h7F;
            if (wdata[7]) begin
               m_cnt = (m_wo[14] << 16) | (m_wo[1] << 8) | m_wo[0];
               m_tc = 0;
            end
            case (c)
               'h00: ;
               'h01: m_q.delete();
               'h02: m_reset();
               'h03: begin
                  m_intr = m_intr | 'h88;
                  if (!m_wo[8][6]) m_int = 1;
                  m_conn = 0;
               end
               'h12: begin m_intr = m_intr | 'h20; m_int = 1; m_step = 4; m_conn = 0; end
               'h1A: m_atn = 1;
               'h1B: m_atn = 0;
               'h10, 'h11, 'h18, 'h41, 'h42, 'h43, 'h44, 'h46: begin
                  if (m_busy) begin m_intr = m_intr | 'h40; m_int = 1; end
                  else begin m_busy = 1; m_req = 1; m_rcmd = wdata; end
               end
               default: begin m_intr = m_intr | 'h40; m_int = 1; end
            endcase
         end
         if (!(wh && i == 3 && (wdata & 'h7F) == 'h02)) begin
            if (rh && i == 5 && m_int) begin
               m_intr = 0; m_step = 0; m_int = 0; m_tc = 0; m_phase = 2;
            end
            if (take) begin
               m_busy = 0; m_phase = sphase; m_step = sstep;
               m_intr = m_intr | sintr; m_int = 1; m_conn = !sintr[5];
               if (stc) begin m_tc = 1; m_cnt = 0; end
            end
         end
      end
   end

   task automatic report(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      #2;
      if (model_on && rst_n && !finished) begin
         report("R2 model rdata", int'(rdata), m_rdata());
         report("R14 model int_o", int'(int_o), int'(m_int));
         report("R10 model atn_o", int'(atn_o), int'(m_atn));
         report("R9 model connected_o", int'(conn_o), int'(m_conn));
         report("R12 model seq_req_o", int'(req_o), int'(m_req));
         if (m_req) report("R12 model seq_cmd_o", int'(cmd_o), m_rcmd);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic drive(bit w, bit r, logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wdata = d; sdone = 1'b0;
   endtask

   function automatic logic [7:0] ax(int idx);
      return stride4 ? 8'(idx << 2) : 8'(idx);
   endfunction

   task automatic wr(int idx, logic [7:0] d); drive(1, 0, ax(idx), d); endtask
   task automatic idle(); drive(0, 0, 8'h00, 8'h00); endtask

   task automatic rdchk_a(logic [7:0] a, int exp, string tag);
      drive(0, 1, a, 8'h00);
      #1;
      report(tag, int'(rdata), exp);
   endtask

   task automatic rdchk(int idx, int exp, string tag);
      rdchk_a(ax(idx), exp, tag);
   endtask

   task automatic seq_finish(logic [2:0] ph, logic [2:0] st, logic [7:0] it, bit tc);
      @(negedge clk);
      wr_en = 0; rd_en = 0; sdone = 1; sphase = ph; sstep = st; sintr = it; stc = tc;
   endtask

   task automatic pin(string tag, logic v, logic e);
      #1;
      report(tag, int'(v), int'(e));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL R12 watchdog expired actual=0x0 expected=0x1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_on = 1;
      // R5 reset state
      rdchk(14, 'h94, "R5 counter high");
      rdchk(9, 'h02, "R5 clock conversion");
      rdchk(4, 'h00, "R5 status");
      rdchk(5, 'h00, "R5 interrupt");
      rdchk(7, 'h00, "R4 flags at reset");
      rdchk(8, 'h07, "R6 own id");
      pin("R14 int_o at reset", int_o, 1'b0);
      // R2 split views
      wr(10, 'hA5);
      rdchk(10, 'hA5, "R2 plain readback");
      rdchk(13, 'h00, "R2 unused index");
      wr(0, 'h34);
      rdchk(0, 'h00, "R2 counter not loaded by write");
      // R7 DMA load
      wr(1, 'h12); wr(14, 'h05); wr(3, 'h80);
      rdchk(0, 'h34, "R7 counter low");
      rdchk(1, 'h12, "R7 counter mid");
      rdchk(14, 'h05, "R7 counter high");
      rdchk(3, 'h80, "R2 command readback");
      // R3 / R4 FIFO
      wr(2, 'h11); wr(2, 'h22); wr(2, 'h33);
      rdchk(7, 'h03, "R4 count 3");
      rdchk(2, 'h11, "R3 pop 1");
      rdchk(2, 'h22, "R3 pop 2");
      rdchk(2, 'h33, "R3 pop 3");
      rdchk(2, 'h00, "R3 empty pop");
      rdchk(7, 'h00, "R3 empty pop unchanged");
      for (int i = 0; i < 17; i++) wr(2, 8'(8'h40 + i));
      rdchk(7, 'h10, "R3 overflow dropped");
      rdchk(2, 'h40, "R3 oldest first");
      rdchk(7, 'h0F, "R4 count after pop");
      wr(3, 'h01);
      rdchk(7, 'h00, "R3 flush");
      // R1 address modes
      idle(); stride4 = 1'b0;
      wr(8, 'h40);
      rdchk_a(8'h08, 'h47, "R1 byte mode cfg1");
      rdchk_a(8'h20, 'h00, "R1 byte mode out of range");
      drive(1, 0, 8'h12, 8'h77);
      rdchk_a(8'h07, 'h00, "R1 out of range write ignored");
      idle(); stride4 = 1'b1;
      rdchk_a(8'h21, 'h47, "R1 stride mode low bits");
      rdchk_a(8'h40, 'h00, "R1 stride mode out of range");
      // R9 bus reset, report disabled
      wr(3, 'h03); idle();
      pin("R9 no int when disabled", int_o, 1'b0);
      rdchk(5, 'h88, "R9 intr bits");
      rdchk(5, 'h88, "R8 no clear without pending");
      wr(3, 'h00);
      rdchk(5, 'h08, "R9 command clears bus-reset bit");
      // R9 bus reset, report enabled
      wr(8, 'h00); wr(3, 'h03); idle();
      pin("R9 int raised", int_o, 1'b1);
      rdchk(4, 'h80, "R9 status");
      rdchk(5, 'h88, "R8 intr read");
      idle();
      pin("R8 int dropped", int_o, 1'b0);
      rdchk(4, 'h02, "R8 status after clear");
      rdchk(5, 'h00, "R8 intr after clear");
      // R11 illegal
      wr(3, 'h05); idle();
      pin("R11 int", int_o, 1'b1);
      rdchk(5, 'h40, "R11 illegal bit");
      // R10 ATN
      wr(3, 'h1A); idle();
      pin("R10 atn set", atn_o, 1'b1);
      wr(3, 'h1B); idle();
      pin("R10 atn clear", atn_o, 1'b0);
      // R12 sequencer
      wr(4, 'h03); wr(0, 'h00); wr(1, 'h02); wr(14, 'h00);
      wr(3, 'hC2); idle();
      pin("R12 request", req_o, 1'b1);
      report("R12 request command", int'(cmd_o), 'hC2);
      report("R12 target id", int'(id_o), 3);
      rdchk(1, 'h02, "R7 counter loaded for select");
      wr(3, 'h10); idle();
      pin("R11 no request when busy", req_o, 1'b0);
      pin("R11 busy illegal int", int_o, 1'b1);
      rdchk(5, 'h40, "R11 busy illegal bit");
      seq_finish(3'd1, 3'd4, 8'h18, 1'b1); idle();
      pin("R12 int on completion", int_o, 1'b1);
      pin("R12 connected", conn_o, 1'b1);
      rdchk(4, 'h91, "R12 status phase and tc");
      rdchk(0, 'h00, "R12 counter zeroed");
      rdchk(7, 'h80, "R4 step in flags");
      rdchk(6, 'h04, "R12 step");
      rdchk(5, 'h18, "R12 intr merged");
      wr(3, 'h41); idle();
      seq_finish(3'd0, 3'd0, 8'h20, 1'b0); idle();
      pin("R12 failed select disconnects", conn_o, 1'b0);
      rdchk(5, 'h20, "R12 disconnect bit");
      seq_finish(3'd3, 3'd3, 8'h10, 1'b0); idle();
      pin("R12 stray completion ignored", int_o, 1'b0);
      // R10 message accepted
      wr(3, 'h12); idle();
      pin("R10 msg accepted int", int_o, 1'b1);
      rdchk(7, 'h80, "R10 step 4");
      rdchk(5, 'h20, "R10 disconnect bit");
      // R13 chip reset
      wr(9, 'h07); wr(2, 'hAA); wr(3, 'h1A); wr(3, 'h02);
      rdchk(9, 'h02, "R13 clock conversion");
      rdchk(14, 'h94, "R13 counter high");
      rdchk(7, 'h00, "R13 fifo empty");
      rdchk(3, 'h00, "R13 command reg");
      pin("R13 atn cleared", atn_o, 1'b0);
      idle(); idle();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule